// File: doc/BRIEF.md
# Three-stage watchdog timer

This block holds a parameterised array of watchdog timers behind a simple single-cycle register bus. Each timer counts down from a software-chosen reload length and, each time it runs out without being poked, escalates one step: a core interrupt first, then a per-timer interrupt to a management processor, then a sticky reset request. A 2-bit mode field per timer decides how far the escalation may go, or stops the timer.

All timers share one prescaler that produces a count tick once every `PRESCALE` clocks. The reload value is the 16-bit length field placed above `ZERO_W` zero bits, so one length unit spans 2^`ZERO_W` ticks. Core interrupts are collected in a pending register with write-one-to-clear semantics and gated by an enable mask that has separate set and clear addresses. The management and reset outputs are consumed by logic outside this block.

Top module: `tri_stage_wdog`

## Requirements
- R1: After rst_ni is released all outputs are 0, every config word reads 0, and the pending (0x200) and enable (0x210/0x218) registers read 0.
- R2: The config word of timer i sits at byte address 8*i with mode in bits [1:0], management-interrupt enable in bit 2, length in bits [19:4] and the live count from bit 20 upward (read-only); writing a nonzero mode to a stopped timer loads count = length shifted left by ZERO_W and starts it at stage one.
- R3: A running timer's count drops by exactly one on each prescaler tick, one tick every PRESCALE clocks; a tick that finds the count at 0 is an expiry and reloads the count.
- R4: In mode 1 every expiry sets the timer's pending bit and never raises the management interrupt or the reset request.
- R5: In mode 2 the first expiry sets the pending bit and the second and later ones raise irq_mgmt_o[i]; the reset request is never raised.
- R6: In mode 3 the first expiry sets the pending bit, the second raises irq_mgmt_o[i], the third raises rst_req_o, which then stays high until rst_ni is asserted.
- R7: With bit 2 of the config word clear, the second stage raises no management interrupt, yet the third expiry still raises the reset request.
- R8: A write with data bit 0 set to byte address 0x10000+8*i reloads timer i, returns it to stage one and clears irq_mgmt_o[i]; a write there with bit 0 clear has no effect, and these addresses read 0.
- R9: Writing to 0x200 clears exactly the pending bits written as 1 (bit i for timer i); bits written as 0 keep their value.
- R10: A write to 0x218 sets and a write to 0x210 clears exactly the enable bits written as 1, both addresses read the enable mask, irq_core_o is high exactly when some timer has pending and enable both set, and a cleared enable does not stop its timer counting.
- R11: Writing mode 0 stops the timer: its count holds, it returns to stage one and its management interrupt clears (as does writing any mode below 2).
- R12: Unmapped or misaligned addresses read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational in the access cycle |
| irq_core_o | output | 1 | OR of pending AND enable over all timers |
| irq_mgmt_o | output | N_TIMERS | Per-timer management interrupt level |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
Timers are run in each of the three active modes with the management enable both set and clear, so the bench can tell a missing stage from a skipped one and a premature reset from a late one. Repeated pokes shorter than the expiry period are contrasted with a poke written with bit 0 clear, which must let the timer expire. Stopping, masking and clearing are applied to a timer with a pending bit already set, which separates effects on the count from effects on the interrupt path, and a behavioural model checks the three outputs on every clock so the exact expiry cycles are pinned down.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_IRQ  = 2'd1;
  localparam logic [1:0] MODE_ESC2 = 2'd2;
  localparam logic [1:0] MODE_FULL = 2'd3;

  localparam logic [1:0] STG_CORE = 2'd0;
  localparam logic [1:0] STG_MGMT = 2'd1;
  localparam logic [1:0] STG_RST  = 2'd2;

  localparam logic [31:0] PEND_ADDR  = 32'h0000_0200;
  localparam logic [31:0] ENCLR_ADDR = 32'h0000_0210;
  localparam logic [31:0] ENSET_ADDR = 32'h0000_0218;
  localparam logic [31:0] POKE_BASE  = 32'h0001_0000;

  typedef struct packed {
    logic cfg_hit;
    logic poke_hit;
    logic pend_hit;
    logic enclr_hit;
    logic enset_hit;
  } dec_t;
endpackage

// File: rtl/tsw_prescaler.sv
module tsw_prescaler #(
  parameter int DIV = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);
endmodule

// File: rtl/tsw_addr_dec.sv
module tsw_addr_dec
  import tsw_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int ADDR_W   = 17,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [31:0] SPAN = 32'(N_TIMERS * 8);

  logic [31:0] a, poke_off;
  logic        aligned;

  assign a        = 32'(addr_i);
  assign poke_off = a - POKE_BASE;
  assign aligned  = (a[2:0] == 3'b000);

  always_comb begin
    hit_o           = '0;
    hit_o.cfg_hit   = aligned && (a < SPAN);
    hit_o.poke_hit  = aligned && (a >= POKE_BASE) && (a < POKE_BASE + SPAN);
    hit_o.pend_hit  = (a == PEND_ADDR);
    hit_o.enclr_hit = (a == ENCLR_ADDR);
    hit_o.enset_hit = (a == ENSET_ADDR);
  end

  assign idx_o = hit_o.cfg_hit ? a[3 +: IDX_W] : poke_off[3 +: IDX_W];

  logic unused_addr;
  assign unused_addr = ^{a, poke_off};
endmodule

// File: rtl/tsw_timer.sv
module tsw_timer
  import tsw_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ZERO_W = 8,
  parameter int CNT_W  = LEN_W + ZERO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             cfg_mgmt_en_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             poke_i,
  output logic [1:0]       mode_o,
  output logic             mgmt_en_o,
  output logic [LEN_W-1:0] len_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             pend_set_o,
  output logic             mgmt_o,
  output logic             rst_o
);
  logic [1:0]       mode_q, stage_q, top_stage, eff_stage;
  logic             mgmt_en_q, mgmt_q, rst_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q, reload_cur, reload_new;

  assign reload_cur = {len_q, {ZERO_W{1'b0}}};
  assign reload_new = {cfg_len_i, {ZERO_W{1'b0}}};
  // deepest stage the mode permits; stage is clamped in case the mode was lowered
  assign top_stage  = mode_q - 2'd1;
  assign eff_stage  = (stage_q > top_stage) ? top_stage : stage_q;

  // bus writes win over a tick in the same cycle
  assign expire_o   = tick_i && (mode_q != MODE_OFF) && (cnt_q == '0) && !cfg_we_i && !poke_i;
  assign pend_set_o = expire_o && (eff_stage == STG_CORE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_OFF;
      mgmt_en_q <= 1'b0;
      len_q     <= '0;
      cnt_q     <= '0;
      stage_q   <= STG_CORE;
      mgmt_q    <= 1'b0;
      rst_q     <= 1'b0;
    end else if (cfg_we_i) begin
      mode_q    <= cfg_mode_i;
      mgmt_en_q <= cfg_mgmt_en_i;
      len_q     <= cfg_len_i;
      if (cfg_mode_i == MODE_OFF) begin
        stage_q <= STG_CORE;
      end else if (mode_q == MODE_OFF) begin
        cnt_q   <= reload_new;
        stage_q <= STG_CORE;
      end
      if (cfg_mode_i < MODE_ESC2) mgmt_q <= 1'b0;
    end else if (poke_i) begin
      cnt_q   <= reload_cur;
      stage_q <= STG_CORE;
      mgmt_q  <= 1'b0;
    end else if (tick_i && (mode_q != MODE_OFF)) begin
      if (cnt_q == '0) begin
        cnt_q <= reload_cur;
        if (eff_stage == STG_MGMT && mgmt_en_q) mgmt_q <= 1'b1;
        if (eff_stage == STG_RST) rst_q <= 1'b1;
        stage_q <= (eff_stage < top_stage) ? eff_stage + 2'd1 : eff_stage;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign mgmt_en_o = mgmt_en_q;
  assign len_o     = len_q;
  assign cnt_o     = cnt_q;
  assign mgmt_o    = mgmt_q;
  assign rst_o     = rst_q;
endmodule

// File: rtl/tri_stage_wdog.sv
module tri_stage_wdog
  import tsw_pkg::*;
#(
  parameter int N_TIMERS = 4,
  parameter int PRESCALE = 1024,
  parameter int LEN_W    = 16,
  parameter int ZERO_W   = 8,
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_core_o,
  output logic [N_TIMERS-1:0] irq_mgmt_o,
  output logic                rst_req_o
);
  localparam int CNT_W   = LEN_W + ZERO_W;
  localparam int LEN_LSB = 4;
  localparam int CNT_LSB = LEN_LSB + LEN_W;
  localparam int IDX_W   = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;

  logic                tick, wr;
  dec_t                hit;
  logic [IDX_W-1:0]    idx;
  logic [N_TIMERS-1:0] cfg_we, poke, expire, pend_set, rst_v, mgmt_en_v;
  logic [N_TIMERS-1:0][1:0]       mode_v;
  logic [N_TIMERS-1:0][LEN_W-1:0] len_v;
  logic [N_TIMERS-1:0][CNT_W-1:0] cnt_v;
  logic [N_TIMERS-1:0] pend_q, en_q, wmask, pend_clr, en_set, en_clr;

  assign wr    = bus_req_i && bus_we_i;
  assign wmask = bus_wdata_i[N_TIMERS-1:0];

  tsw_prescaler #(.DIV(PRESCALE)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  tsw_addr_dec #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_dec (
    .addr_i (bus_addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    assign cfg_we[i] = wr && hit.cfg_hit && (idx == IDX_W'(i));
    assign poke[i]   = wr && hit.poke_hit && (idx == IDX_W'(i)) && bus_wdata_i[0];

    tsw_timer #(.LEN_W(LEN_W), .ZERO_W(ZERO_W), .CNT_W(CNT_W)) i_tmr (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .tick_i        (tick),
      .cfg_we_i      (cfg_we[i]),
      .cfg_mode_i    (bus_wdata_i[1:0]),
      .cfg_mgmt_en_i (bus_wdata_i[2]),
      .cfg_len_i     (bus_wdata_i[LEN_LSB +: LEN_W]),
      .poke_i        (poke[i]),
      .mode_o        (mode_v[i]),
      .mgmt_en_o     (mgmt_en_v[i]),
      .len_o         (len_v[i]),
      .cnt_o         (cnt_v[i]),
      .expire_o      (expire[i]),
      .pend_set_o    (pend_set[i]),
      .mgmt_o        (irq_mgmt_o[i]),
      .rst_o         (rst_v[i])
    );
  end

  assign pend_clr = (wr && hit.pend_hit)  ? wmask : '0;
  assign en_set   = (wr && hit.enset_hit) ? wmask : '0;
  assign en_clr   = (wr && hit.enclr_hit) ? wmask : '0;

  // a new expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      en_q   <= (en_q | en_set) & ~en_clr;
    end
  end

  assign irq_core_o = |(pend_q & en_q);
  assign rst_req_o  = |rst_v;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      if (hit.cfg_hit) begin
        bus_rdata_o[1:0]                = mode_v[idx];
        bus_rdata_o[2]                  = mgmt_en_v[idx];
        bus_rdata_o[LEN_LSB +: LEN_W]   = len_v[idx];
        bus_rdata_o[CNT_LSB +: CNT_W]   = cnt_v[idx];
      end else if (hit.pend_hit) begin
        bus_rdata_o[N_TIMERS-1:0] = pend_q;
      end else if (hit.enclr_hit || hit.enset_hit) begin
        bus_rdata_o[N_TIMERS-1:0] = en_q;
      end
    end
  end

  logic unused_dec;
  assign unused_dec = ^{expire, hit.poke_hit};
endmodule

// File: rtl/tri_stage_wdog_chk.sv
module tri_stage_wdog_chk #(
  parameter int N     = 4,
  parameter int CNT_W = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick,
  input logic [N-1:0]       cfg_we,
  input logic [N-1:0]       poke,
  input logic [N-1:0]       expire,
  input logic [N-1:0]       pend_q,
  input logic [N-1:0][1:0]  mode_v,
  input logic [N-1:0][CNT_W-1:0] cnt_v,
  input logic [N-1:0]       irq_mgmt_o,
  input logic               rst_req_o
);
  p_rst_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  p_rst_from_expiry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(|expire));

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_cnt_moves_on_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ($stable(cnt_v[i]) || $past(tick) || $past(cfg_we[i]) || $past(poke[i])));

    p_mgmt_needs_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_mgmt_o[i] |-> (mode_v[i] >= 2'd2));

    p_stopped_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_v[i] == 2'd0 && !cfg_we[i] && !poke[i]) |=> $stable(cnt_v[i]));

    p_pend_from_expiry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> $past(expire[i]));
  end
endmodule

bind tri_stage_wdog tri_stage_wdog_chk #(.N(N_TIMERS), .CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick       (tick),
  .cfg_we     (cfg_we),
  .poke       (poke),
  .expire     (expire),
  .pend_q     (pend_q),
  .mode_v     (mode_v),
  .cnt_v      (cnt_v),
  .irq_mgmt_o (irq_mgmt_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/test_tri_stage_wdog.sv
`timescale 1ns/1ps
module test_tri_stage_wdog;
  localparam int NT = 2;
  localparam int P  = 4;
  localparam int LW = 16;
  localparam int ZW = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [16:0] addr;
  logic [63:0] wdata, rdata;
  logic        irq_core;
  logic [NT-1:0] irq_mgmt;
  logic        rst_req;

  int checks = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tri_stage_wdog #(.N_TIMERS(NT), .PRESCALE(P), .LEN_W(LW), .ZERO_W(ZW),
                   .ADDR_W(17), .DATA_W(64)) i_tri_stage_wdog (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_core_o(irq_core), .irq_mgmt_o(irq_mgmt), .rst_req_o(rst_req));

  // behavioural reference model
  int m_mode[NT], m_men[NT], m_len[NT], m_cnt[NT], m_stage[NT], m_mgmt[NT], m_rst[NT];
  int m_pend, m_en, m_pre;

  always @(posedge clk) begin : model
    int tick, pclr, eset, eclr, pset, top, eff, nm;
    bit cw, pk;
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        m_mode[i] = 0; m_men[i] = 0; m_len[i] = 0; m_cnt[i] = 0;
        m_stage[i] = 0; m_mgmt[i] = 0; m_rst[i] = 0;
      end
      m_pend = 0; m_en = 0; m_pre = 0;
    end else begin
      tick = (m_pre == P - 1) ? 1 : 0;
      pclr = 0; eset = 0; eclr = 0; pset = 0;
      if (req && we) begin
        if (addr == 17'h200) pclr = int'(wdata[NT-1:0]);
        if (addr == 17'h218) eset = int'(wdata[NT-1:0]);
        if (addr == 17'h210) eclr = int'(wdata[NT-1:0]);
      end
      for (int i = 0; i < NT; i++) begin
        cw = req && we && (addr == 17'(8 * i));
        pk = req && we && (addr == 17'(32'h10000 + 8 * i)) && wdata[0];
        if (cw) begin
          nm = int'(wdata[1:0]);
          if (nm == 0) m_stage[i] = 0;
          else if (m_mode[i] == 0) begin
            m_cnt[i] = int'(wdata[19:4]) << ZW;
            m_stage[i] = 0;
          end
          if (nm < 2) m_mgmt[i] = 0;
          m_mode[i] = nm; m_men[i] = int'(wdata[2]); m_len[i] = int'(wdata[19:4]);
        end else if (pk) begin
          m_cnt[i] = m_len[i] << ZW; m_stage[i] = 0; m_mgmt[i] = 0;
        end else if (tick == 1 && m_mode[i] != 0) begin
          if (m_cnt[i] == 0) begin
            m_cnt[i] = m_len[i] << ZW;
            top = m_mode[i] - 1;
            eff = (m_stage[i] > top) ? top : m_stage[i];
            if (eff == 0) pset = pset | (1 << i);
            if (eff == 1 && m_men[i] == 1) m_mgmt[i] = 1;
            if (eff == 2) m_rst[i] = 1;
            m_stage[i] = (eff < top) ? eff + 1 : eff;
          end else m_cnt[i] = m_cnt[i] - 1;
        end
      end
      m_pend = (m_pend & ~pclr) | pset;
      m_en = (m_en | eset) & ~eclr;
      m_pre = (m_pre + 1) % P;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] cfgw(input int mode, input int men, input int len);
    return 64'(mode) | (64'(men) << 2) | (64'(len) << 4);
  endfunction

  function automatic longint exp_cfg(input int i);
    return longint'(m_mode[i]) | (longint'(m_men[i]) << 2) |
           (longint'(m_len[i]) << 4) | (longint'(m_cnt[i]) << 20);
  endfunction

  // per-clock comparison of the outputs (R4 R5 R6 R7 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 per-cycle irq_core_o", longint'(irq_core), ((m_pend & m_en) != 0) ? 1 : 0);
      chk("R5 per-cycle irq_mgmt_o", longint'(irq_mgmt), longint'(m_mgmt[0] | (m_mgmt[1] << 1)));
      chk("R6 per-cycle rst_req_o", longint'(rst_req), ((m_rst[0] | m_rst[1]) != 0) ? 1 : 0);
    end
  end

  task automatic idle(input int n);
    req = 0; we = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [63:0] v);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #2 v = rdata;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 0; req = 0; we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin : stim
    logic [63:0] v, v1, v2;
    req = 0; we = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R1 irq_core_o after reset", longint'(irq_core), 0);
    chk("R1 irq_mgmt_o after reset", longint'(irq_mgmt), 0);
    chk("R1 rst_req_o after reset", longint'(rst_req), 0);
    rd(17'h0, v);   chk("R1 config word 0", longint'(v), 0);
    rd(17'h200, v); chk("R1 pending", longint'(v), 0);
    rd(17'h218, v); chk("R1 enable", longint'(v), 0);

    // R12: unmapped and misaligned accesses
    wr(17'h300, '1);
    wr(17'h004, cfgw(3, 1, 5));
    rd(17'h300, v); chk("R12 unmapped read", longint'(v), 0);
    rd(17'h208, v); chk("R12 gap read", longint'(v), 0);
    rd(17'h0, v);   chk("R12 misaligned write ignored", longint'(v), 0);
    rd(17'h218, v); chk("R12 unmapped write left enables", longint'(v), 0);

    // R2 / R3: long timer 0 in mode 1
    wr(17'h0, cfgw(1, 0, 100));
    rd(17'h0, v);   chk("R2 config word with live count", longint'(v), exp_cfg(0));
    chk("R2 count loaded from length", longint'(v[37:20]) >> 2, 100);
    rd(17'h0, v1);
    repeat (3) @(negedge clk);
    rd(17'h0, v2);
    chk("R3 one step per prescaler period", longint'(v1[37:20]) - longint'(v2[37:20]), 1);
    wr(17'h0, cfgw(0, 0, 100));

    // R4: timer 1 in mode 1
    wr(17'h8, cfgw(1, 0, 1));
    idle(100);
    rd(17'h200, v); chk("R4 pending set by expiry", longint'(v), 2);
    chk("R4 no management interrupt", longint'(irq_mgmt), 0);
    chk("R4 no reset request", longint'(rst_req), 0);

    // R10: enable set / clear
    wr(17'h218, 64'h2);
    chk("R10 enabled pending drives irq_core_o", longint'(irq_core), 1);
    wr(17'h210, 64'h2);
    chk("R10 cleared enable masks irq_core_o", longint'(irq_core), 0);
    rd(17'h218, v); chk("R10 enable readback", longint'(v), 0);
    rd(17'h8, v1);
    repeat (7) @(negedge clk);
    rd(17'h8, v2);
    chk("R10 masked timer keeps counting", (v1[37:20] != v2[37:20]) ? 1 : 0, 1);

    // R11: stop holds count
    wr(17'h8, cfgw(0, 0, 1));
    rd(17'h8, v1);
    idle(40);
    rd(17'h8, v2);
    chk("R11 stopped count holds", longint'(v2), longint'(v1));

    // R9: write-one-to-clear
    wr(17'h200, 64'h0);
    rd(17'h200, v); chk("R9 zero bits leave pending", longint'(v), 2);
    wr(17'h200, 64'h2);
    rd(17'h200, v); chk("R9 one bit clears pending", longint'(v), 0);

    // R5: timer 1 in mode 2
    wr(17'h8, cfgw(2, 1, 1));
    idle(60);
    chk("R5 management interrupt after second expiry", longint'(irq_mgmt), 2);
    rd(17'h200, v); chk("R5 first expiry set pending", longint'(v), 2);
    idle(80);
    chk("R5 never resets", longint'(rst_req), 0);

    // R8: poke
    wr(17'h10008, 64'h1);
    chk("R8 poke clears management interrupt", longint'(irq_mgmt), 0);
    wr(17'h200, 64'h2);
    for (int k = 0; k < 10; k++) begin
      idle(8);
      wr(17'h10008, 64'h1);
    end
    rd(17'h200, v);   chk("R8 pokes hold off expiry", longint'(v), 0);
    rd(17'h10008, v); chk("R8 poke address reads zero", longint'(v), 0);
    wr(17'h10008, 64'h0);
    idle(30);
    rd(17'h200, v);   chk("R8 poke with bit 0 clear has no effect", longint'(v), 2);
    wr(17'h8, cfgw(0, 0, 1));

    // R6: timer 0 in mode 3 with management enabled
    wr(17'h200, 64'h3);
    wr(17'h0, cfgw(3, 1, 2));
    idle(50);
    rd(17'h200, v); chk("R6 first stage pending", longint'(v), 1);
    chk("R6 no management yet", longint'(irq_mgmt), 0);
    idle(40);
    chk("R6 second stage management", longint'(irq_mgmt), 1);
    chk("R6 no reset before third", longint'(rst_req), 0);
    idle(30);
    chk("R6 third stage reset", longint'(rst_req), 1);
    idle(50);
    chk("R6 reset held", longint'(rst_req), 1);
    pulse_reset();
    chk("R6 reset cleared by rst_ni", longint'(rst_req), 0);

    // R7: mode 3 without management enable
    wr(17'h0, cfgw(3, 0, 2));
    idle(90);
    chk("R7 second stage skipped", longint'(irq_mgmt), 0);
    chk("R7 no reset yet", longint'(rst_req), 0);
    idle(35);
    chk("R7 third stage still resets", longint'(rst_req), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule